// File: doc/BRIEF.md
# Cascaded FIFO Ring Token Controller

This block is the per-device control slice that lets several FIFO devices be chained into a closed ring so that together they act as one deeper buffer. Each device holds or lacks a write token and a read token. The two tokens move around the ring independently. Only the holder of the write token may accept writes, and only the holder of the read token may supply reads. A device hands a token to the next device by pulsing a cascade output. That output is wired to the next device's cascade input, and the last device feeds back to the first. The FIFO storage is outside this block. The block sees the local full and empty conditions and returns gated local write and read enables.

A strap input picks the starting device. The one device whose strap is tied low comes out of reset holding both tokens, and every other device is tied high. The write token leaves a device once that device has filled. The read token leaves once the device has been filled, the write token has moved on, and the device has been drained. Each device flips a toggle when it fills and another when it drains, and each toggle is resynchronised into the other clock domain. These toggles stop a returning writer from appending to a device whose earlier contents are still being read. They also stop a reader from leaving a device that is still being written.

Setting the cascade parameter to zero turns the block into a stand-alone device. In that mode the enables depend only on full and empty, and the write cascade pin carries the local half-full flag.

Top module: `fifo_ring_token_ctrl`

## Requirements
- R1: While reset is active, a device with first_load_ni low holds both tokens and a device with it high holds neither. Neither cascade output is high during reset.
- R2: wr_en_o is high exactly when wr_req_i is high, the device holds the write token, full_i is low, and no earlier fill of this device is still waiting to be read out (R6).
- R3: rd_en_o is high exactly when rd_req_i is high, the device holds the read token and empty_i is low.
- R4: A write-token holder that has accepted at least one write since taking the token, and sees full_i high at a wclk edge, drops the token at that edge and drives wr_cas_o high for exactly one wclk cycle. With a full flag that rises one cycle after the filling write, the pulse is seen two cycles after that write's cycle.
- R5: A device that sees wr_cas_i high at a wclk edge holds the write token from that edge on. Its first write enable can therefore appear three cycles after the previous holder's last write.
- R6: A device that has passed on the write token after filling accepts no write until its read token has since left it (drained), even when full_i is low.
- R7: A read-token holder that sees empty_i high, and was filled since its read token last left, drops the read token at that rclk edge and drives rd_cas_o high for exactly one rclk cycle. A device that sees rd_cas_i high at an rclk edge holds the read token from that edge on.
- R8: A read-token holder on an empty device that has not been filled since its read token last left keeps the token, and rd_cas_o stays low.
- R9: Across a ring, at most one device is write-enabled and at most one is read-enabled in any cycle. Words leave the ring in the order they entered it, and the ring holds the sum of the device depths.
- R10: With CASCADE_EN = 0, wr_en_o is wr_req_i with full_i low, rd_en_o is rd_req_i with empty_i low, wr_cas_o follows half_full_i, and rd_cas_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock, shared around the ring |
| rclk_i | input | 1 | Read-side clock, shared around the ring |
| rst_ni | input | 1 | Asynchronous active-low reset |
| first_load_ni | input | 1 | Strap, low on the device that starts with both tokens |
| wr_req_i | input | 1 | Write request from the shared write port |
| rd_req_i | input | 1 | Read request from the shared read port |
| full_i | input | 1 | Local storage full |
| empty_i | input | 1 | Local storage empty |
| half_full_i | input | 1 | Local half-full flag, routed out in stand-alone mode |
| wr_cas_i | input | 1 | Write token pulse from the previous device |
| rd_cas_i | input | 1 | Read token pulse from the previous device |
| wr_en_o | output | 1 | Gated local write enable |
| rd_en_o | output | 1 | Gated local read enable |
| wr_cas_o | output | 1 | Write token pulse to the next device, or half-full in stand-alone mode |
| rd_cas_o | output | 1 | Read token pulse to the next device |

## Verification
The bench builds a ring of three devices with the default two-stage resynchronisers, each backed by a modelled store four words deep. One more instance is built with the cascade parameter at zero. Because the ring holds only twelve words, a few dozen cycles reach full wrap-around, exact handoff cycle counts and a writer stalled on an undrained device. A reader parked on a device that is still being written is also reached. The stand-alone instance gets an exhaustive sweep over all 32 combinations of its request, flag and half-full inputs.

// File: rtl/ring_tok_pkg.sv
package ring_tok_pkg;
  parameter int unsigned SYNC_STAGES_DFLT = 2;

  typedef enum logic {
    TOK_IDLE = 1'b0,
    TOK_HELD = 1'b1
  } tok_state_e;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ring_wr_token.sv
module ring_wr_token
  import ring_tok_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic req_i,
  input  logic full_i,
  input  logic cas_i,
  input  logic drain_tgl_i,
  output logic en_o,
  output logic cas_o,
  output logic fill_tgl_o
);
  tok_state_e tok_q;
  logic       wrote_q;
  logic       cas_q;
  logic       fill_q;
  logic       held;
  logic       pending;
  logic       pass;

  assign held    = (tok_q == TOK_HELD);
  // earlier fill not yet drained by the reader
  assign pending = fill_q ^ drain_tgl_i;
  assign pass    = held & wrote_q & full_i;
  assign en_o    = req_i & held & ~full_i & ~pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q   <= lead_i ? TOK_HELD : TOK_IDLE;
      wrote_q <= 1'b0;
      cas_q   <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      cas_q <= pass;
      if (en_o) wrote_q <= 1'b1;
      if (pass) begin
        tok_q   <= TOK_IDLE;
        wrote_q <= 1'b0;
        fill_q  <= ~fill_q;
      end
      if (cas_i) begin
        tok_q   <= TOK_HELD;
        wrote_q <= 1'b0;
      end
    end
  end

  assign cas_o      = cas_q;
  assign fill_tgl_o = fill_q;
endmodule

// File: rtl/ring_rd_token.sv
module ring_rd_token
  import ring_tok_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic req_i,
  input  logic empty_i,
  input  logic cas_i,
  input  logic fill_tgl_i,
  output logic en_o,
  output logic cas_o,
  output logic drain_tgl_o
);
  tok_state_e tok_q;
  logic       cas_q;
  logic       drain_q;
  logic       held;
  logic       pending;
  logic       pass;

  assign held    = (tok_q == TOK_HELD);
  assign pending = fill_tgl_i ^ drain_q;
  assign pass    = held & empty_i & pending;
  assign en_o    = req_i & held & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q   <= lead_i ? TOK_HELD : TOK_IDLE;
      cas_q   <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      cas_q <= pass;
      if (pass) begin
        tok_q   <= TOK_IDLE;
        drain_q <= ~drain_q;
      end
      if (cas_i) tok_q <= TOK_HELD;
    end
  end

  assign cas_o       = cas_q;
  assign drain_tgl_o = drain_q;
endmodule

// File: rtl/fifo_ring_token_ctrl.sv
module fifo_ring_token_ctrl
  import ring_tok_pkg::*;
#(
  parameter bit          CASCADE_EN  = 1'b1,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DFLT
) (
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic first_load_ni,
  input  logic wr_req_i,
  input  logic rd_req_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic half_full_i,
  input  logic wr_cas_i,
  input  logic rd_cas_i,
  output logic wr_en_o,
  output logic rd_en_o,
  output logic wr_cas_o,
  output logic rd_cas_o
);
  if (CASCADE_EN) begin : g_ring
    logic lead;
    logic fill_tgl_w;
    logic fill_tgl_r;
    logic drain_tgl_r;
    logic drain_tgl_w;
    logic unused_ring;

    assign lead        = ~first_load_ni;
    assign unused_ring = half_full_i;

    ring_sync #(.STAGES(SYNC_STAGES)) u_fill_sync (
      .clk_i (rclk_i),
      .rst_ni(rst_ni),
      .d_i   (fill_tgl_w),
      .q_o   (fill_tgl_r)
    );

    ring_sync #(.STAGES(SYNC_STAGES)) u_drain_sync (
      .clk_i (wclk_i),
      .rst_ni(rst_ni),
      .d_i   (drain_tgl_r),
      .q_o   (drain_tgl_w)
    );

    ring_wr_token u_wr (
      .clk_i      (wclk_i),
      .rst_ni     (rst_ni),
      .lead_i     (lead),
      .req_i      (wr_req_i),
      .full_i     (full_i),
      .cas_i      (wr_cas_i),
      .drain_tgl_i(drain_tgl_w),
      .en_o       (wr_en_o),
      .cas_o      (wr_cas_o),
      .fill_tgl_o (fill_tgl_w)
    );

    ring_rd_token u_rd (
      .clk_i      (rclk_i),
      .rst_ni     (rst_ni),
      .lead_i     (lead),
      .req_i      (rd_req_i),
      .empty_i    (empty_i),
      .cas_i      (rd_cas_i),
      .fill_tgl_i (fill_tgl_r),
      .en_o       (rd_en_o),
      .cas_o      (rd_cas_o),
      .drain_tgl_o(drain_tgl_r)
    );
  end else begin : g_solo
    logic unused_solo;
    assign unused_solo = ^{wr_cas_i, rd_cas_i, first_load_ni, wclk_i, rclk_i, rst_ni};
    assign wr_en_o  = wr_req_i & ~full_i;
    assign rd_en_o  = rd_req_i & ~empty_i;
    // shared pin carries the half-full flag when not chained
    assign wr_cas_o = half_full_i;
    assign rd_cas_o = 1'b0;
  end
endmodule

// File: rtl/fifo_ring_token_ctrl_chk.sv
module fifo_ring_token_ctrl_chk #(
  parameter bit CASCADE_EN = 1'b1
) (
  input logic wclk_i,
  input logic rclk_i,
  input logic rst_ni,
  input logic wr_req_i,
  input logic rd_req_i,
  input logic full_i,
  input logic empty_i,
  input logic wr_cas_i,
  input logic wr_en_o,
  input logic rd_en_o,
  input logic wr_cas_o,
  input logic rd_cas_o
);
  p_wr_gate_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_req_i && !full_i));

  p_rd_gate_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_req_i && !empty_i));

  if (CASCADE_EN) begin : g_ring_props
    p_wr_pulse_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      wr_cas_o |=> !wr_cas_o);

    p_wr_release_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      wr_cas_o |-> !wr_en_o);

    p_wr_cause_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      $rose(wr_cas_o) |-> $past(full_i));

    p_wr_take_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
      wr_cas_i |=> !wr_cas_o);

    p_rd_pulse_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      rd_cas_o |=> !rd_cas_o);

    p_rd_release_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      rd_cas_o |-> !rd_en_o);

    p_rd_cause_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      $rose(rd_cas_o) |-> $past(empty_i));
  end
endmodule

bind fifo_ring_token_ctrl fifo_ring_token_ctrl_chk #(.CASCADE_EN(CASCADE_EN)) u_chk (
  .wclk_i  (wclk_i),
  .rclk_i  (rclk_i),
  .rst_ni  (rst_ni),
  .wr_req_i(wr_req_i),
  .rd_req_i(rd_req_i),
  .full_i  (full_i),
  .empty_i (empty_i),
  .wr_cas_i(wr_cas_i),
  .wr_en_o (wr_en_o),
  .rd_en_o (rd_en_o),
  .wr_cas_o(wr_cas_o),
  .rd_cas_o(rd_cas_o)
);

// File: tb/fifo_ring_token_ctrl_tb.sv
module fifo_ring_token_ctrl_tb;
  localparam int N = 3;
  localparam int D = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic wr_req, rd_req;
  logic [N-1:0] wr_en, rd_en, wcas, rcas, full, empty;

  int cnt [N];
  int wp  [N];
  int rp  [N];
  int mem [N][D];
  int wr_seq, rd_seq;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  for (genvar i = 0; i < N; i++) begin : g_dev
    fifo_ring_token_ctrl #(.CASCADE_EN(1'b1)) u_dut (
      .wclk_i       (clk),
      .rclk_i       (clk),
      .rst_ni       (rst_n),
      .first_load_ni((i == 0) ? 1'b0 : 1'b1),
      .wr_req_i     (wr_req),
      .rd_req_i     (rd_req),
      .full_i       (full[i]),
      .empty_i      (empty[i]),
      .half_full_i  (1'b0),
      .wr_cas_i     (wcas[(i + N - 1) % N]),
      .rd_cas_i     (rcas[(i + N - 1) % N]),
      .wr_en_o      (wr_en[i]),
      .rd_en_o      (rd_en[i]),
      .wr_cas_o     (wcas[i]),
      .rd_cas_o     (rcas[i])
    );
    assign full[i]  = (cnt[i] == D);
    assign empty[i] = (cnt[i] == 0);
  end

  // stand-alone instance
  logic s_wr_req, s_rd_req, s_full, s_empty, s_half;
  logic s_wr_en, s_rd_en, s_wcas, s_rcas;
  fifo_ring_token_ctrl #(.CASCADE_EN(1'b0)) u_dut_solo (
    .wclk_i       (clk),
    .rclk_i       (clk),
    .rst_ni       (rst_n),
    .first_load_ni(1'b1),
    .wr_req_i     (s_wr_req),
    .rd_req_i     (s_rd_req),
    .full_i       (s_full),
    .empty_i      (s_empty),
    .half_full_i  (s_half),
    .wr_cas_i     (1'b0),
    .rd_cas_i     (1'b0),
    .wr_en_o      (s_wr_en),
    .rd_en_o      (s_rd_en),
    .wr_cas_o     (s_wcas),
    .rd_cas_o     (s_rcas)
  );

  // storage model: flags follow one cycle after the access
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < N; d++) begin
        cnt[d] <= 0;
        wp[d]  <= 0;
        rp[d]  <= 0;
      end
      wr_seq <= 0;
      rd_seq <= 0;
    end else begin
      for (int d = 0; d < N; d++) begin
        if (wr_en[d]) begin
          mem[d][wp[d]] <= wr_seq;
          wp[d] <= (wp[d] + 1) % D;
        end
        if (rd_en[d]) begin
          chk(mem[d][rp[d]] == rd_seq, "R9 read order", mem[d][rp[d]], rd_seq);
          rp[d] <= (rp[d] + 1) % D;
        end
        cnt[d] <= cnt[d] + (wr_en[d] ? 1 : 0) - (rd_en[d] ? 1 : 0);
      end
      if (|wr_en) wr_seq <= wr_seq + 1;
      if (|rd_en) rd_seq <= rd_seq + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  int first [N];
  int last  [N];
  int p_at  [N];
  int pulses[N];
  int base;

  task automatic clr_track();
    for (int d = 0; d < N; d++) begin
      first[d]  = -1;
      last[d]   = -1;
      p_at[d]   = -1;
      pulses[d] = 0;
    end
  endtask

  initial begin
    rst_n = 1'b1;
    wr_req = 1'b0; rd_req = 1'b0;
    s_wr_req = 1'b0; s_rd_req = 1'b0; s_full = 1'b0; s_empty = 1'b0; s_half = 1'b0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(wr_en == '0, "R1 reset wr_en idle", int'(wr_en), 0);
    chk(wcas == '0 && rcas == '0, "R1 reset cascade low", int'({wcas, rcas}), 0);
    wr_req = 1'b1; rd_req = 1'b1;
    #1;
    chk(wr_en == 3'b001, "R1 strap low owns write token", int'(wr_en), 1);
    chk(rd_en == 3'b000, "R3 empty blocks read", int'(rd_en), 0);
    wr_req = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // phase A: fill the whole ring
    clr_track();
    for (int c = 0; c < 40; c++) begin
      wr_req = 1'b1;
      #1;
      chk($countones(wr_en) <= 1, "R9 single writer", $countones(wr_en), 1);
      for (int d = 0; d < N; d++) begin
        if (wr_en[d]) begin
          if (first[d] < 0) first[d] = c;
          last[d] = c;
        end
        if (wcas[d]) begin
          pulses[d]++;
          p_at[d] = c;
        end
      end
      @(negedge clk);
    end
    chk(first[0] == 0 && last[0] == D - 1, "R2 first device takes four writes", last[0], D - 1);
    chk(p_at[0] == last[0] + 2, "R4 write pulse after fill", p_at[0], last[0] + 2);
    chk(first[1] == last[0] + 3, "R5 next device takes write token", first[1], last[0] + 3);
    chk(p_at[1] == last[1] + 2, "R4 second device pulse", p_at[1], last[1] + 2);
    chk(first[2] == last[1] + 3, "R5 third device takes write token", first[2], last[1] + 3);
    for (int d = 0; d < N; d++)
      chk(pulses[d] == 1, "R4 single write pulse per device", pulses[d], 1);
    chk(wr_seq == N * D, "R9 ring capacity", wr_seq, N * D);
    chk(wr_en == '0, "R6 writer stalls on full undrained device", int'(wr_en), 0);

    // phase B: drain, first three cycles with writes requested
    clr_track();
    for (int c = 0; c < 64; c++) begin
      wr_req = (c < 3);
      rd_req = 1'b1;
      #1;
      chk($countones(rd_en) <= 1, "R9 single reader", $countones(rd_en), 1);
      if (c < 3) begin
        chk(wr_en == '0, "R6 no write into undrained device", int'(wr_en), 0);
        chk(rd_en == 3'b001, "R3 read from first device", int'(rd_en), 1);
      end
      for (int d = 0; d < N; d++) begin
        if (rd_en[d]) begin
          if (first[d] < 0) first[d] = c;
          last[d] = c;
        end
        if (rcas[d]) begin
          pulses[d]++;
          p_at[d] = c;
        end
      end
      @(negedge clk);
    end
    chk(rd_seq == N * D, "R9 all words read", rd_seq, N * D);
    chk(p_at[0] == last[0] + 2, "R7 read pulse after drain", p_at[0], last[0] + 2);
    chk(first[1] == last[0] + 3, "R7 next device takes read token", first[1], last[0] + 3);
    for (int d = 0; d < N; d++)
      chk(pulses[d] == 1, "R7 single read pulse per device", pulses[d], 1);

    // R8: writer back on first device, reader must wait there
    for (int c = 0; c < 2; c++) begin
      wr_req = 1'b1; rd_req = 1'b0;
      #1;
      chk(wr_en == 3'b001, "R5 write token returned to first device", int'(wr_en), 1);
      @(negedge clk);
    end
    base = 0;
    for (int c = 0; c < 12; c++) begin
      wr_req = 1'b0; rd_req = 1'b1;
      #1;
      base += $countones(rcas);
      @(negedge clk);
    end
    chk(base == 0, "R8 reader holds on unfilled device", base, 0);
    chk(rd_seq == N * D + 2, "R8 partial words read", rd_seq, N * D + 2);

    // phase C: mixed traffic, then fast then slow reader
    for (int c = 0; c < 500; c++) begin
      wr_req = ((c % 3) != 0) || ((c % 7) == 0);
      rd_req = (c < 250) ? ((c % 5) != 1) : ((c % 4) == 0);
      #1;
      chk($countones(wr_en) <= 1 && $countones(rd_en) <= 1, "R9 one writer and one reader",
          $countones(wr_en) + $countones(rd_en), 2);
      @(negedge clk);
    end
    for (int c = 0; c < 120; c++) begin
      wr_req = 1'b0; rd_req = 1'b1;
      @(negedge clk);
    end
    #1;
    chk(rd_seq == wr_seq, "R9 drain returns every word", rd_seq, wr_seq);
    chk(wr_seq > 200, "R9 traffic made progress", wr_seq, 201);
    chk(cnt[0] + cnt[1] + cnt[2] == 0, "R9 ring empty after drain", cnt[0] + cnt[1] + cnt[2], 0);
    wr_req = 1'b0; rd_req = 1'b0;

    // stand-alone sweep
    for (int v = 0; v < 32; v++) begin
      {s_wr_req, s_rd_req, s_full, s_empty, s_half} = 5'(v);
      #1;
      chk(s_wr_en == (s_wr_req & ~s_full) && s_rd_en == (s_rd_req & ~s_empty),
          "R10 solo enables", int'({s_wr_en, s_rd_en}),
          int'({s_wr_req & ~s_full, s_rd_req & ~s_empty}));
      chk(s_wcas == s_half && s_rcas == 1'b0, "R10 solo cascade pins",
          int'({s_wcas, s_rcas}), int'({s_half, 1'b0}));
    end

    summary();
    $finish;
  end
endmodule